// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block watches a heartbeat line driven by a processor and raises a reset request when that line stops changing. Time is measured in ticks of an external timebase strobe. After every reset event the block starts in a boot mode with a long window, so that a slow start-up has time to finish. The first heartbeat edge it sees moves it to a run mode with a much shorter window. In either mode, a rising or a falling heartbeat edge counts as service and restarts the window.

If the window runs out with no edge, the block issues a one-cycle expiry request to the reset sequencer. It then goes quiet until the sequencer pulses the release strobe. That pulse, or any other reset release the sequencer reports through the same strobe, puts the block back in boot mode with a fresh window. A connection-enable input switches the watchdog off completely when the heartbeat pin is reported as unconnected. The system reset level holds the timer cleared.

Top module: `dual_wdt`

## Requirements
- R1: While `rst` is high, `expire_o` stays 0 and timebase ticks are not counted. After `rst` falls, the block is in boot mode with an empty window.
- R2: In boot mode with no heartbeat edge, `expire_o` pulses in the cycle after the `START_TICKS`-th tick counted since the window started, and not before.
- R3: The first heartbeat edge in boot mode switches the block to run mode. From then on, an expiry follows the `NORM_TICKS`-th tick with no edge.
- R4: A rising heartbeat edge and a falling heartbeat edge each clear the window.
- R5: `expire_o` is high for exactly one clock cycle per expiry.
- R6: After an expiry, the block counts no ticks, ignores heartbeat edges and issues no further request until `rls_i` is high for a cycle.
- R7: A cycle with `rls_i` high returns the block to boot mode with an empty window. This happens from run mode as well as after an expiry.
- R8: While `hb_en_i` is low, the window is held empty, no expiry is issued and heartbeat edges do not change the mode.
- R9: The heartbeat passes through a two-flop synchronizer before edge detection. When an edge and a tick reach the counter in the same cycle, the edge wins: the window is cleared and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset level, synchronous, active high |
| tick_i | input | 1 | Timebase strobe; one window unit per cycle high |
| hb_i | input | 1 | Asynchronous heartbeat from the processor |
| hb_en_i | input | 1 | High when the heartbeat pin is connected; low disables the watchdog |
| rls_i | input | 1 | Reset-release strobe from the reset sequencer |
| expire_o | output | 1 | One-cycle reset request on window expiry |

## Verification
The internal state of this block shows at the ports only through the timing of `expire_o`. A mode held wrongly shows as an expiry after the wrong number of ticks, either 20 where 6 are due or the reverse. A window that is not cleared shows as an early expiry on the next count. A dropped block after expiry shows as a second request within a few ticks. Each scenario therefore counts ticks up to the exact expiry point and checks that one tick fewer gives no request. A wrong state is visible within one window length, at most `START_TICKS` ticks.

// File: rtl/dwd_pkg.sv
package dwd_pkg;

    typedef enum logic [1:0] {
        WD_BOOT = 2'd0,
        WD_RUN  = 2'd1,
        WD_HALT = 2'd2
    } wd_mode_t;

    typedef struct packed {
        logic rls;
        logic en;
        logic svc;
        logic tick;
    } wd_evt_t;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/dwd_hb_sync.sv
module dwd_hb_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hb_i,
    output logic edge_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Free-running chain: reset must last longer than SYNC_STAGES + 1 cycles
    // so that the chain holds real samples when edges are first qualified.
    always_ff @(posedge clk) begin
        chain_q[0] <= hb_i;
        prev_q     <= chain_q[LAST];
    end

    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    always_comb begin
        edge_o = ~rst & (chain_q[LAST] ^ prev_q);
    end

endmodule

// File: rtl/dwd_mode_fsm.sv
module dwd_mode_fsm
    import dwd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wd_evt_t  evt_i,
    input  logic     hit_i,
    output wd_mode_t mode_o,
    output logic     run_o,
    output logic     svc_o
);
    wd_mode_t mode_q, mode_d;

    always_comb begin
        run_o = evt_i.en & ~evt_i.rls & (mode_q != WD_HALT);
        svc_o = run_o & evt_i.svc;
    end

    always_comb begin
        mode_d = mode_q;
        if (evt_i.rls) begin
            mode_d = WD_BOOT;
        end else if (run_o) begin
            if (evt_i.svc) begin
                mode_d = WD_RUN;
            end else if (hit_i) begin
                mode_d = WD_HALT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= WD_BOOT;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/dwd_win_cnt.sv
module dwd_win_cnt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic [CW-1:0] limit_i,
    output logic          hit_o
);
    logic [CW-1:0] cnt_q;

    always_comb begin
        hit_o = adv_i & ~clr_i & (cnt_q == (limit_i - 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i || hit_o) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dual_wdt.sv
module dual_wdt
    import dwd_pkg::*;
#(
    parameter int unsigned START_TICKS = 54000,
    parameter int unsigned NORM_TICKS  = 1680,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic hb_i,
    input  logic hb_en_i,
    input  logic rls_i,
    output logic expire_o
);
    localparam int unsigned CW = cnt_width(START_TICKS, NORM_TICKS);
    localparam logic [CW-1:0] START_LIM = CW'(START_TICKS);
    localparam logic [CW-1:0] NORM_LIM  = CW'(NORM_TICKS);

    logic          hb_edge;
    wd_evt_t       evt;
    wd_mode_t      mode;
    logic          run;
    logic          svc;
    logic          hit;
    logic [CW-1:0] limit;
    logic          expire_q;

    dwd_hb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .hb_i  (hb_i),
        .edge_o(hb_edge)
    );

    always_comb begin
        evt.rls  = rls_i;
        evt.en   = hb_en_i;
        evt.svc  = hb_edge;
        evt.tick = tick_i;
    end

    dwd_mode_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt),
        .hit_i (hit),
        .mode_o(mode),
        .run_o (run),
        .svc_o (svc)
    );

    always_comb begin
        limit = (mode == WD_RUN) ? NORM_LIM : START_LIM;
    end

    dwd_win_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (~run | svc),
        .adv_i  (evt.tick),
        .limit_i(limit),
        .hit_o  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            expire_q <= 1'b0;
        end else begin
            expire_q <= hit;
        end
    end

    assign expire_o = expire_q;

endmodule

// File: rtl/dual_wdt_chk.sv
module dual_wdt_chk (
    input logic clk,
    input logic rst,
    input logic tick_i,
    input logic hb_en_i,
    input logic rls_i,
    input logic expire_o
);
    logic halted_q;

    always_ff @(posedge clk) begin
        if (rst || rls_i) begin
            halted_q <= 1'b0;
        end else if (expire_o) begin
            halted_q <= 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !expire_o);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !expire_o);

    // R6
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        halted_q |-> !expire_o);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !hb_en_i |=> !expire_o);

    // R2
    tick_cause_chk: assert property (@(posedge clk) disable iff (rst)
        expire_o |-> $past(tick_i));

endmodule

bind dual_wdt dual_wdt_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .hb_en_i (hb_en_i),
    .rls_i   (rls_i),
    .expire_o(expire_o)
);

// File: tb/dual_wdt_bench.sv
module dual_wdt_bench;
    localparam int CLK_PERIOD = 10;
    localparam int START_T = 20;
    localparam int NORM_T  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b0;
    logic hb_i = 1'b0;
    logic hb_en_i = 1'b1;
    logic rls_i = 1'b0;
    logic expire_o;

    int total = 0;
    int bad = 0;
    int hit_at;
    int hits;
    int wide;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_wdt #(.START_TICKS(START_T), .NORM_TICKS(NORM_T), .SYNC_STAGES(2)) u_dual_wdt (
        .clk(clk), .rst(rst), .tick_i(tick_i), .hb_i(hb_i),
        .hb_en_i(hb_en_i), .rls_i(rls_i), .expire_o(expire_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulses n ticks; records the first tick index followed by a request,
    // the number of requests and any request lasting more than one cycle.
    task automatic run_ticks(input int n);
        hit_at = 0; hits = 0; wide = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (expire_o) wide++;
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            if (expire_o) begin
                hits++;
                if (hit_at == 0) hit_at = i;
            end
        end
        @(negedge clk);
        if (expire_o) wide++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hb_en_i = 1'b1; rls_i = 1'b0; tick_i = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic toggle_hb();
        @(negedge clk);
        hb_i = ~hb_i;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_rls();
        @(negedge clk);
        rls_i = 1'b1;
        @(negedge clk);
        rls_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        check(expire_o == 1'b0, "R1 idle in reset", expire_o, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            if (expire_o) wide++;
        end
        check(wide == 0, "R1 no request in reset", wide, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run_ticks(START_T - 1);
        check(hits == 0, "R1 window empty after reset", hits, 0);
        run_ticks(1);
        check(hit_at == 1, "R1 boot window from release", hit_at, 1);
    endtask

    task automatic t_boot();
        do_reset();
        run_ticks(START_T + 5);
        check(hit_at == START_T, "R2 boot expiry tick", hit_at, START_T);
        check(wide == 0, "R5 single-cycle request", wide, 0);
        check(hits == 1, "R6 one request only", hits, 1);
        toggle_hb();
        run_ticks(3 * START_T);
        check(hits == 0, "R6 silent until release", hits, 0);
        pulse_rls();
        run_ticks(START_T - 1);
        check(hits == 0, "R7 boot window after release", hits, 0);
        run_ticks(1);
        check(hit_at == 1, "R7 boot expiry after release", hit_at, 1);
    endtask

    task automatic t_normal();
        do_reset();
        toggle_hb();
        run_ticks(NORM_T);
        check(hit_at == NORM_T, "R3 run window length", hit_at, NORM_T);
        pulse_rls();
        toggle_hb();
        run_ticks(NORM_T - 2);
        pulse_rls();
        run_ticks(START_T);
        check(hit_at == START_T, "R7 release from run mode", hit_at, START_T);
    endtask

    task automatic t_edges();
        do_reset();
        toggle_hb();
        run_ticks(NORM_T - 1);
        check(hits == 0, "R4 rising edge served", hits, 0);
        toggle_hb();
        run_ticks(NORM_T - 1);
        check(hits == 0, "R4 falling edge clears", hits, 0);
        run_ticks(1);
        check(hit_at == 1, "R4 expiry after falling edge", hit_at, 1);
    endtask

    task automatic t_disable();
        do_reset();
        run_ticks(10);
        @(negedge clk); hb_en_i = 1'b0;
        run_ticks(4 * START_T);
        check(hits == 0, "R8 no request while disabled", hits, 0);
        toggle_hb();
        @(negedge clk); hb_en_i = 1'b1;
        run_ticks(START_T - 1);
        check(hits == 0, "R8 window cleared and mode kept", hits, 0);
        run_ticks(1);
        check(hit_at == 1, "R8 boot expiry after enable", hit_at, 1);
    endtask

    task automatic t_collide();
        do_reset();
        toggle_hb();
        run_ticks(NORM_T - 1);
        // edge reaches the counter two cycles after the pin changes
        @(negedge clk); hb_i = ~hb_i;
        @(negedge clk);
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        check(expire_o == 1'b0, "R9 edge beats tick", expire_o, 0);
        run_ticks(NORM_T - 1);
        check(hits == 0, "R9 tick not counted", hits, 0);
        run_ticks(1);
        check(hit_at == 1, "R9 expiry after full window", hit_at, 1);
    endtask

    initial begin
        t_reset();
        t_boot();
        t_normal();
        t_edges();
        t_disable();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule